// File: doc/BRIEF.md
# Receive-Side Switch Tag Stripper

This block sits on the receive path of a host port wired to the management port of an Ethernet switch. Frames arrive one byte per cycle with valid, last and ready handshaking. The switch may insert a 4-byte tag right after the two MAC addresses. That tag is a private EtherType (0x8899) followed by a 16-bit big-endian word. The word's top nibble names a tag protocol, and its low byte names the switch port the frame entered on.

The block holds the first 18 bytes of every frame in a header buffer: both addresses, the tag and the EtherType behind it. It then classifies the frame with one of three verdicts. An untagged frame goes out unchanged. A frame tagged with the supported protocol (0xA) goes out with the 4 tag bytes cut out and the addresses closed up against the inner EtherType. With that frame it reports the source port and the inner EtherType as sideband metadata. A frame tagged with any other protocol is discarded whole and an error pulse is raised. Frames too short to classify are discarded as runts. Three saturating counters record passed, stripped and dropped frames.

The controller has five states. COLLECT accepts header bytes. JUDGE spends one cycle on classification. EMIT replays the buffered header and, when stripping, skips the tag bytes. STREAM forwards the rest of the frame straight through. DISCARD swallows the rest of a rejected frame. The transitions are:
- COLLECT to JUDGE on the 18th byte.
- COLLECT to COLLECT on a runt's last byte.
- JUDGE to EMIT on a pass or strip verdict.
- JUDGE to DISCARD, or back to COLLECT when the frame already ended, on a drop verdict.
- EMIT to STREAM, or to COLLECT when the frame ended inside the header, after the final header byte.
- STREAM and DISCARD to COLLECT on the frame's last input byte.

Top module: `rx_tag_stripper`

## Requirements
- R1: A frame of at least 18 bytes whose bytes 12–13 (byte 12 most significant) differ from 0x8899 leaves byte for byte unchanged and with the same length. `out_port_valid` stays 0 and `out_etype` equals bytes 12–13.
- R2: A frame of at least 18 bytes with bytes 12–13 equal to 0x8899 and with the upper nibble of byte 14 equal to 0xA is stripped. The output is bytes 0–11 followed by bytes 16 onward, so it is 4 bytes shorter.
- R3: On a stripped frame, `out_port_valid` is 1, `out_port` equals byte 15 (the low 8 bits of the tag word) and `out_etype` equals bytes 16–17.
- R4: A frame with bytes 12–13 equal to 0x8899 and any upper nibble of byte 14 other than 0xA produces no output bytes. `err_proto` is high for exactly one cycle per such frame, and the drop counter advances.
- R5: A frame that ends before its 18th byte produces no output, raises no `err_proto` and advances the drop counter.
- R6: `out_port`, `out_port_valid` and `out_etype` do not change from a frame's first output byte through its last output byte.
- R7: When `out_ready` is low, a presented output byte stays presented with the same data and last flag. No byte is lost or repeated, and `out_last` marks only the final byte.
- R8: `cnt_pass`, `cnt_strip` and `cnt_drop` each step by one per frame of their class and saturate at all ones.
- R9: After reset all counters read 0, `out_valid` is 0, `out_port_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Incoming frame byte |
| in_valid | input | 1 | Incoming byte present |
| in_last | input | 1 | Incoming byte ends the frame |
| in_ready | output | 1 | Block accepts the incoming byte |
| out_data | output | 8 | Outgoing frame byte |
| out_valid | output | 1 | Outgoing byte present |
| out_last | output | 1 | Outgoing byte ends the frame |
| out_ready | input | 1 | Downstream accepts the outgoing byte |
| out_port | output | 8 | Source switch port of the current frame |
| out_port_valid | output | 1 | Current frame carried a stripped tag |
| out_etype | output | 16 | EtherType of the payload for flow classification |
| err_proto | output | 1 | One-cycle pulse for a tag of an unsupported protocol |
| cnt_pass | output | CNT_W | Frames passed unchanged, saturating |
| cnt_strip | output | CNT_W | Frames stripped, saturating |
| cnt_drop | output | CNT_W | Frames dropped (foreign protocol or runt), saturating |

## Verification
The hold checks on the output assume the source side obeys the same rule. Once `in_valid` is raised, it and `in_data`/`in_last` stay put until the byte is taken, because the STREAM state passes them straight to the output. The bench driver changes a byte only after it has been accepted, and inserts idle gaps only between accepted bytes. The metadata checks assume a frame's bytes are not interleaved with another frame's. The bench sends frames strictly one after another and lets the output drain fully before the next one starts.

// File: rtl/tagstrip_pkg.sv
package tagstrip_pkg;

    localparam int MAC_BYTES   = 12;
    localparam int TAG_BYTES   = 4;
    localparam int ETYPE_BYTES = 2;
    localparam int HDR_BYTES   = MAC_BYTES + TAG_BYTES + ETYPE_BYTES;
    localparam int TAIL_BYTES  = HDR_BYTES - MAC_BYTES;
    localparam int IDX_W       = $clog2(HDR_BYTES);

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_JUDGE,
        ST_EMIT,
        ST_STREAM,
        ST_DISCARD
    } ts_state_e;

    typedef enum logic [1:0] {
        VD_PASS,
        VD_STRIP,
        VD_DROP
    } ts_verdict_e;

endpackage

// File: rtl/ts_hdr_buf.sv
module ts_hdr_buf
    import tagstrip_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [7:0]              wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [7:0]              rd_data,
    output logic [TAIL_BYTES*8-1:0] tail_flat
);

    logic [7:0] bytes_w [HDR_BYTES];

    for (genvar k = 0; k < HDR_BYTES; k++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(k)) begin
                slot_q <= wr_data;
            end
        end
        assign bytes_w[k] = slot_q;
        if (k >= MAC_BYTES) begin : g_tail
            assign tail_flat[(k-MAC_BYTES)*8 +: 8] = slot_q;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < HDR_BYTES; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = bytes_w[k];
        end
    end

endmodule

// File: rtl/ts_classify.sv
module ts_classify
    import tagstrip_pkg::*;
#(
    parameter logic [15:0] TAG_ETYPE = 16'h8899,
    parameter logic [3:0]  TAG_PROTO = 4'hA
) (
    input  logic [TAIL_BYTES*8-1:0] tail_flat,
    output ts_verdict_e             verdict,
    output logic [7:0]              port,
    output logic [15:0]             etype
);

    // tail_flat byte 0 is frame byte 12
    logic [15:0] outer_type;
    logic [15:0] tag_word;
    logic [15:0] inner_type;
    logic        unused_tag_bits;

    assign outer_type      = {tail_flat[0*8 +: 8], tail_flat[1*8 +: 8]};
    assign tag_word        = {tail_flat[2*8 +: 8], tail_flat[3*8 +: 8]};
    assign inner_type      = {tail_flat[4*8 +: 8], tail_flat[5*8 +: 8]};
    assign unused_tag_bits = ^tag_word[11:8];

    always_comb begin
        if (outer_type != TAG_ETYPE) begin
            verdict = VD_PASS;
            etype   = outer_type;
        end else if (tag_word[15:12] == TAG_PROTO) begin
            verdict = VD_STRIP;
            etype   = inner_type;
        end else begin
            verdict = VD_DROP;
            etype   = outer_type;
        end
        port = tag_word[7:0];
    end

endmodule

// File: rtl/ts_sat_counter.sv
module ts_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    logic [W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (inc && value_q != {W{1'b1}}) begin
            value_q <= value_q + 1'b1;
        end
    end

    assign value = value_q;

endmodule

// File: rtl/rx_tag_stripper.sv
module rx_tag_stripper
    import tagstrip_pkg::*;
#(
    parameter int          CNT_W     = 16,
    parameter logic [15:0] TAG_ETYPE = 16'h8899,
    parameter logic [3:0]  TAG_PROTO = 4'hA
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready,
    output logic [7:0]       out_port,
    output logic             out_port_valid,
    output logic [15:0]      out_etype,
    output logic             err_proto,
    output logic [CNT_W-1:0] cnt_pass,
    output logic [CNT_W-1:0] cnt_strip,
    output logic [CNT_W-1:0] cnt_drop
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] MAC_END  = IDX_W'(MAC_BYTES - 1);
    localparam logic [IDX_W-1:0] SKIP_TO  = IDX_W'(MAC_BYTES + TAG_BYTES);
    localparam int               N_CNT    = 3;

    ts_state_e        state_q, state_d;
    logic [IDX_W-1:0] wr_idx_q, wr_idx_d;
    logic [IDX_W-1:0] rd_idx_q, rd_idx_d;
    logic             hdr_last_q;
    ts_verdict_e      verdict_q;
    logic [7:0]       port_q;
    logic [15:0]      etype_q;
    logic             meta_ok_q;

    logic                    accept;
    logic                    wr_en;
    logic [7:0]              buf_rd;
    logic [TAIL_BYTES*8-1:0] tail_flat;
    ts_verdict_e             cls_verdict;
    logic [7:0]              cls_port;
    logic [15:0]             cls_etype;
    logic [N_CNT-1:0]        cnt_inc;
    logic [CNT_W-1:0]        cnt_val [N_CNT];

    ts_hdr_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx_q),
        .wr_data  (in_data),
        .rd_idx   (rd_idx_q),
        .rd_data  (buf_rd),
        .tail_flat(tail_flat)
    );

    ts_classify #(
        .TAG_ETYPE(TAG_ETYPE),
        .TAG_PROTO(TAG_PROTO)
    ) u_cls (
        .tail_flat(tail_flat),
        .verdict  (cls_verdict),
        .port     (cls_port),
        .etype    (cls_etype)
    );

    // index 0: pass, 1: strip, 2: drop
    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        ts_sat_counter #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (cnt_inc[g]),
            .value(cnt_val[g])
        );
    end

    assign cnt_pass  = cnt_val[0];
    assign cnt_strip = cnt_val[1];
    assign cnt_drop  = cnt_val[2];

    assign accept = in_valid && in_ready;
    assign wr_en  = accept && (state_q == ST_COLLECT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: begin
                if (accept && wr_idx_q == LAST_IDX) state_d = ST_JUDGE;
            end
            ST_JUDGE: begin
                if (cls_verdict == VD_DROP)
                    state_d = hdr_last_q ? ST_COLLECT : ST_DISCARD;
                else
                    state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (out_ready && rd_idx_q == LAST_IDX)
                    state_d = hdr_last_q ? ST_COLLECT : ST_STREAM;
            end
            ST_STREAM: begin
                if (accept && in_last) state_d = ST_COLLECT;
            end
            ST_DISCARD: begin
                if (accept && in_last) state_d = ST_COLLECT;
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = buf_rd;
        out_last  = 1'b0;
        err_proto = 1'b0;
        cnt_inc   = '0;
        wr_idx_d  = wr_idx_q;
        rd_idx_d  = rd_idx_q;
        unique case (state_q)
            ST_COLLECT: begin
                in_ready = 1'b1;
                if (accept) begin
                    if (wr_idx_q == LAST_IDX) begin
                        wr_idx_d = '0;
                    end else if (in_last) begin
                        wr_idx_d   = '0;
                        cnt_inc[2] = 1'b1;
                    end else begin
                        wr_idx_d = wr_idx_q + 1'b1;
                    end
                end
            end
            ST_JUDGE: begin
                rd_idx_d = '0;
                unique case (cls_verdict)
                    VD_PASS:  cnt_inc[0] = 1'b1;
                    VD_STRIP: cnt_inc[1] = 1'b1;
                    default: begin
                        cnt_inc[2] = 1'b1;
                        err_proto  = 1'b1;
                    end
                endcase
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                out_last  = hdr_last_q && (rd_idx_q == LAST_IDX);
                if (out_ready && rd_idx_q != LAST_IDX) begin
                    if (verdict_q == VD_STRIP && rd_idx_q == MAC_END)
                        rd_idx_d = SKIP_TO;
                    else
                        rd_idx_d = rd_idx_q + 1'b1;
                end
            end
            ST_STREAM: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                out_data  = in_data;
                out_last  = in_last;
            end
            ST_DISCARD: begin
                in_ready = 1'b1;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx_q   <= '0;
            rd_idx_q   <= '0;
            hdr_last_q <= 1'b0;
            verdict_q  <= VD_PASS;
            port_q     <= '0;
            etype_q    <= '0;
            meta_ok_q  <= 1'b0;
        end else begin
            wr_idx_q <= wr_idx_d;
            rd_idx_q <= rd_idx_d;
            if (wr_en && wr_idx_q == LAST_IDX) hdr_last_q <= in_last;
            if (state_q == ST_JUDGE) begin
                verdict_q <= cls_verdict;
                port_q    <= cls_port;
                etype_q   <= cls_etype;
                meta_ok_q <= (cls_verdict == VD_STRIP);
            end
        end
    end

    assign out_port       = port_q;
    assign out_etype      = etype_q;
    assign out_port_valid = meta_ok_q &&
                            (state_q == ST_EMIT || state_q == ST_STREAM);

endmodule

// File: rtl/ts_checker.sv
module ts_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       out_data,
    input logic             out_valid,
    input logic             out_last,
    input logic             out_ready,
    input logic [7:0]       out_port,
    input logic             out_port_valid,
    input logic [15:0]      out_etype,
    input logic             err_proto,
    input logic [CNT_W-1:0] cnt_pass,
    input logic [CNT_W-1:0] cnt_strip,
    input logic [CNT_W-1:0] cnt_drop
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

    AST_META_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=>
            ($stable(out_port) && $stable(out_port_valid) && $stable(out_etype))); // R6

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |=> !err_proto); // R4

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |-> !out_valid); // R4

    AST_ERR_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        err_proto |=> (cnt_drop == CNT_W'($past(cnt_drop) + 1'b1) || $past(cnt_drop) == {CNT_W{1'b1}})); // R4

    AST_PASS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_pass != $past(cnt_pass)) |-> (cnt_pass == CNT_W'($past(cnt_pass) + 1'b1))); // R8

    AST_STRIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_strip != $past(cnt_strip)) |-> (cnt_strip == CNT_W'($past(cnt_strip) + 1'b1))); // R8

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_drop != $past(cnt_drop)) |-> (cnt_drop == CNT_W'($past(cnt_drop) + 1'b1))); // R8

endmodule

bind rx_tag_stripper ts_checker #(.CNT_W(CNT_W)) u_ts_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_last      (out_last),
    .out_ready     (out_ready),
    .out_port      (out_port),
    .out_port_valid(out_port_valid),
    .out_etype     (out_etype),
    .err_proto     (err_proto),
    .cnt_pass      (cnt_pass),
    .cnt_strip     (cnt_strip),
    .cnt_drop      (cnt_drop)
);

// File: tb/tb_rx_tag_stripper.sv
module tb_rx_tag_stripper;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 3;
    localparam int SAT        = (1 << CNT_W) - 1;
    localparam int MAXB       = 64;
    localparam int WD_CYCLES  = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       in_data = '0;
    logic             in_valid = 1'b0;
    logic             in_last = 1'b0;
    logic             in_ready;
    logic [7:0]       out_data;
    logic             out_valid;
    logic             out_last;
    logic             out_ready = 1'b0;
    logic [7:0]       out_port;
    logic             out_port_valid;
    logic [15:0]      out_etype;
    logic             err_proto;
    logic [CNT_W-1:0] cnt_pass;
    logic [CNT_W-1:0] cnt_strip;
    logic [CNT_W-1:0] cnt_drop;

    rx_tag_stripper #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .out_port(out_port), .out_port_valid(out_port_valid), .out_etype(out_etype),
        .err_proto(err_proto),
        .cnt_pass(cnt_pass), .cnt_strip(cnt_strip), .cnt_drop(cnt_drop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // downstream back-pressure pattern, includes multi-cycle stalls
    always @(negedge clk) begin
        out_ready = ((cyc % 7) != 3) && ((cyc % 23) >= 3);
    end

    // output capture
    logic [7:0]  cap [MAXB];
    int          cap_n = 0;
    int          last_pos = -1;
    int          err_seen = 0;
    logic [7:0]  m_port;
    logic        m_pv;
    logic [15:0] m_et;
    bit          meta_moved = 0;

    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (err_proto) err_seen++;
            if (out_valid && out_ready) begin
                if (cap_n == 0) begin
                    m_port = out_port; m_pv = out_port_valid; m_et = out_etype;
                end else if (out_port != m_port || out_port_valid != m_pv || out_etype != m_et) begin
                    meta_moved = 1;
                end
                if (cap_n < MAXB) cap[cap_n] = out_data;
                if (out_last) last_pos = cap_n;
                cap_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > SAT) ? SAT : v;
    endfunction

    logic [7:0] fr  [MAXB];
    logic [7:0] ex  [MAXB];
    int exp_pass = 0, exp_strip = 0, exp_drop = 0;
    int fidx = 0;

    // kind: 0 untagged, 1 tag with proto arg, 2 near-miss 0x8898, 3 near-miss 0x9899
    task automatic run_frame(input int len, input int kind, input int proto);
        int ex_n, cls, ex_port, ex_et;
        string rq;
        fidx++;
        for (int i = 0; i < MAXB; i++) fr[i] = 8'(i * 29 + fidx * 13 + 1);
        case (kind)
            0: begin fr[12] = 8'h08; fr[13] = 8'h00; end
            1: begin fr[12] = 8'h88; fr[13] = 8'h99;
                     fr[14] = {4'(proto), 4'(fidx)}; fr[15] = 8'(fidx * 37 + 5); end
            2: begin fr[12] = 8'h88; fr[13] = 8'h98; end
            default: begin fr[12] = 8'h98; fr[13] = 8'h99; end
        endcase
        // classes: 0 pass, 1 strip, 2 proto drop, 3 runt
        if (len < 18)                                  cls = 3;
        else if (kind != 1)                            cls = 0;
        else if (proto == 10)                          cls = 1;
        else                                           cls = 2;
        ex_n = 0; ex_port = 0; ex_et = 0;
        if (cls == 0) begin
            for (int i = 0; i < len; i++) begin ex[ex_n] = fr[i]; ex_n++; end
            ex_et = {fr[12], fr[13]};
            exp_pass++; rq = "R1";
        end else if (cls == 1) begin
            for (int i = 0; i < len; i++) if (i < 12 || i > 15) begin ex[ex_n] = fr[i]; ex_n++; end
            ex_et = {fr[16], fr[17]}; ex_port = fr[15];
            exp_strip++; rq = "R2";
        end else if (cls == 2) begin
            exp_drop++; rq = "R4";
        end else begin
            exp_drop++; rq = "R5";
        end

        cap_n = 0; last_pos = -1; err_seen = 0; meta_moved = 0;

        // drive bytes; hold each until accepted
        begin
            int i = 0;
            bit holding = 0;
            while (i < len) begin
                @(negedge clk);
                if (!holding) begin
                    in_valid = ((cyc % 5) != 2);
                    in_data  = fr[i];
                    in_last  = (i == len - 1);
                end
                #1;
                if (in_valid && in_ready) begin i++; holding = 0; end
                else holding = in_valid;
            end
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
        end
        repeat (80) @(posedge clk);
        @(negedge clk); #3;

        check(cap_n == ex_n, {rq, " length"}, cap_n, ex_n);
        begin
            int bad = -1;
            for (int i = 0; i < ex_n && i < cap_n; i++) if (bad < 0 && cap[i] != ex[i]) bad = i;
            check(bad < 0, {rq, "/R7 content"}, (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(ex[bad]));
        end
        if (ex_n > 0) begin
            check(last_pos == ex_n - 1, "R7 last flag", last_pos, ex_n - 1);
            check(!meta_moved, "R6 meta held", int'(meta_moved), 0);
            check(m_pv == (cls == 1), (cls == 1) ? "R3 port valid" : "R1 port valid", int'(m_pv), int'(cls == 1));
            check(int'(m_et) == ex_et, (cls == 1) ? "R3 etype" : "R1 etype", int'(m_et), ex_et);
            if (cls == 1) check(int'(m_port) == ex_port, "R3 port", int'(m_port), ex_port);
        end
        check(err_seen == (cls == 2), (cls == 3) ? "R5 no error" : "R4 error pulse", err_seen, int'(cls == 2));
        check(int'(cnt_pass)  == sat(exp_pass),  "R8 pass count",  int'(cnt_pass),  sat(exp_pass));
        check(int'(cnt_strip) == sat(exp_strip), "R8 strip count", int'(cnt_strip), sat(exp_strip));
        check(int'(cnt_drop)  == sat(exp_drop),  "R8 drop count",  int'(cnt_drop),  sat(exp_drop));
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        // R9 reset state
        check(cnt_pass == 0 && cnt_strip == 0 && cnt_drop == 0, "R9 counters", int'(cnt_pass) + int'(cnt_strip) + int'(cnt_drop), 0);
        check(!out_valid, "R9 out_valid", int'(out_valid), 0);
        check(!out_port_valid, "R9 port valid", int'(out_port_valid), 0);
        check(in_ready, "R9 in_ready", int'(in_ready), 1);

        // exhaustive protocol nibble sweep on tagged frames (R2, R4)
        for (int p = 0; p < 16; p++) run_frame(22, 1, p);
        // length sweep across every frame class, including runts (R5) and header-only frames
        for (int k = 0; k < 4; k++) begin
            for (int l = 1; l <= 24; l++) run_frame(l, k, (k == 1) ? 10 : 0);
            run_frame(40, k, 10);
            run_frame(MAXB, k, 3);
        end
        finish_run();
    end

endmodule